// File: doc/BRIEF.md
# Three-Wire Serial Slave Access Port

This block lets an external host read and write a 14-bit byte address space over three pins: an active-low select, a serial clock and a single data line that changes direction. Every transfer opens with two address bytes. The first holds the upper six address bits, one ignored bit and a direction flag. The second holds the lower eight address bits. Any number of data bytes may follow, and the address steps by one after each byte. All bytes travel least significant bit first, and the data line is sampled on rising serial-clock edges.

On the internal side the block has a plain synchronous byte port. It gives one-cycle write strobes carrying address and data, and one-cycle read strobes with a read value that comes back on the next system clock. All three serial inputs pass through two-flop synchronisers into the system clock, which must run at least four times the serial clock rate. Edges are detected after synchronisation. In read mode the block takes over the data line once the second address byte is complete. It keeps driving it until select returns high.

Top module: `ser3_port`

## Requirements
- R1: After reset, the data-line enable, write strobe and read strobe are all low.
- R2: The first byte is received in this bit order: address bits 8 to 13, then one bit that is ignored, then the direction flag (0 = write, 1 = read). The ignored bit has no effect on the address used.
- R3: The second byte carries address bits 0 to 7, least significant bit first. Each data byte written by the host is also taken least significant bit first.
- R4: In write mode, each complete data byte produces exactly one single-cycle write strobe with the current address and that byte. The address then increments, wrapping from 0x3FFF to 0x0000.
- R5: In read mode, a read strobe is issued for the received address once the second byte ends. The data line is then driven with the fetched byte, least significant bit first, one bit per serial clock, and changes on falling serial-clock edges.
- R6: In a read burst, each byte after the first comes from the previous address plus one.
- R7: The data-line enable stays high from the first read byte until select goes high, and drops within the synchroniser latency after that.
- R8: Raising select in the middle of a byte aborts the transfer. The partial byte writes nothing, and the next transfer starts again with address bytes.
- R9: While select is high, serial-clock and data activity cause no strobe and no driving of the data line.
- R10: A write transfer issues no read strobes, and the data line is never driven while a write strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n_i | input | 1 | Active-low transfer select from host |
| sck_i | input | 1 | Serial clock from host, high when select falls |
| sda_i | input | 1 | Data line as seen at the pad input |
| sda_o | output | 1 | Data value driven onto the line in read mode |
| sda_oe_o | output | 1 | Enable for driving the data line |
| mem_addr_o | output | 14 | Byte address of the internal access |
| mem_wr_o | output | 1 | One-cycle write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rd_o | output | 1 | One-cycle read strobe |
| mem_rdata_i | input | 8 | Read data, valid one clock after the read strobe |

## Verification
The assertions assume the host obeys the serial timing rules. Each serial-clock level lasts at least two system clocks, so after synchronisation consecutive serial edges are at least two cycles apart and write strobes never come back to back. They also assume select changes only while the serial clock is high and well away from a rising edge, so an abort never lands in the same cycle as the last bit of a byte. The stimulus holds every serial-clock level for five system clocks, changes data together with the falling clock edge, and moves select only with the clock high and after settling waits. The read turnaround is given eight idle cycles before the first data bit.

// File: rtl/ser3_pkg.sv
package ser3_pkg;

    localparam int ADDR_W = 14;
    localparam int BYTE_W = 8;
    localparam int HI_W   = ADDR_W - BYTE_W;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AHI,
        ST_ALO,
        ST_WR,
        ST_RD
    } ser3_state_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } ser3_req_t;

    function automatic logic [ADDR_W-1:0] join_addr(
        input logic [HI_W-1:0]   hi,
        input logic [BYTE_W-1:0] lo
    );
        return {hi, lo};
    endfunction

endpackage

// File: rtl/ser3_sync.sv
module ser3_sync #(
    parameter int WIDTH             = 3,
    parameter int STAGES            = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= RST_VAL;
                else     stage_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= RST_VAL;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/ser3_edge.sv
module ser3_edge #(
    parameter bit   RISING  = 1'b1,
    parameter logic IDLE_LV = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic hit_o
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= IDLE_LV;
        else     prev_q <= lvl_i;
    end

    if (RISING) begin : g_rise
        assign hit_o = lvl_i & ~prev_q;
    end else begin : g_fall
        assign hit_o = ~lvl_i & prev_q;
    end

endmodule

// File: rtl/ser3_ctrl.sv
module ser3_ctrl
    import ser3_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_s_i,
    input  logic              sel_fall_i,
    input  logic              sck_rise_i,
    input  logic              sck_fall_i,
    input  logic              sda_s_i,
    input  logic [BYTE_W-1:0] rdata_i,
    output ser3_req_t         req_o,
    output logic              sda_o,
    output logic              sda_oe_o
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam int               RW_POS   = BYTE_W - 1;

    ser3_state_e       state_q;
    logic [BYTE_W-2:0] shift_q;
    logic [CNT_W-1:0]  bit_q;
    logic [HI_W-1:0]   hi_q;
    logic              rw_q;
    logic [ADDR_W-1:0] cur_q;
    logic              load_q;
    logic [BYTE_W-1:0] tx_q;
    logic              sdo_q;
    logic              oe_q;
    ser3_req_t         req_q;

    logic [BYTE_W-1:0] byte_in;
    logic [ADDR_W-1:0] addr_full;

    assign byte_in   = {sda_s_i, shift_q};
    assign addr_full = join_addr(hi_q, byte_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            shift_q <= '0;
            bit_q   <= '0;
            hi_q    <= '0;
            rw_q    <= 1'b0;
            cur_q   <= '0;
            load_q  <= 1'b0;
            tx_q    <= '0;
            sdo_q   <= 1'b0;
            oe_q    <= 1'b0;
            req_q   <= '0;
        end else begin
            req_q.wr <= 1'b0;
            req_q.rd <= 1'b0;
            load_q   <= req_q.rd;

            if (state_q == ST_IDLE && sel_fall_i) begin
                state_q <= ST_AHI;
                bit_q   <= '0;
            end

            if (load_q && state_q == ST_RD) begin
                tx_q  <= rdata_i;
                sdo_q <= rdata_i[0];
                oe_q  <= 1'b1;
            end

            if (sck_fall_i && state_q == ST_RD && bit_q != '0) begin
                sdo_q <= tx_q[bit_q];
            end

            if (sck_rise_i && state_q != ST_IDLE) begin
                shift_q <= byte_in[BYTE_W-1:1];
                bit_q   <= bit_q + 1'b1;
                if (bit_q == LAST_BIT) begin
                    unique case (state_q)
                        ST_AHI: begin
                            hi_q    <= byte_in[HI_W-1:0];
                            rw_q    <= byte_in[RW_POS];
                            state_q <= ST_ALO;
                        end
                        ST_ALO: begin
                            if (rw_q) begin
                                req_q.addr <= addr_full;
                                req_q.rd   <= 1'b1;
                                cur_q      <= addr_full + 1'b1;
                                state_q    <= ST_RD;
                            end else begin
                                cur_q   <= addr_full;
                                state_q <= ST_WR;
                            end
                        end
                        ST_WR: begin
                            req_q.addr <= cur_q;
                            req_q.data <= byte_in;
                            req_q.wr   <= 1'b1;
                            cur_q      <= cur_q + 1'b1;
                        end
                        ST_RD: begin
                            req_q.addr <= cur_q;
                            req_q.rd   <= 1'b1;
                            cur_q      <= cur_q + 1'b1;
                        end
                        default: state_q <= ST_IDLE;
                    endcase
                end
            end

            if (sel_s_i) begin
                state_q <= ST_IDLE;
                oe_q    <= 1'b0;
                bit_q   <= '0;
                load_q  <= 1'b0;
            end
        end
    end

    assign req_o    = req_q;
    assign sda_o    = sdo_q;
    assign sda_oe_o = oe_q;

    // R4: a write strobe lasts exactly one cycle
    a_r4_wr_pulse: assert property (@(posedge clk) disable iff (rst)
        req_q.wr |=> !req_q.wr);

    // R5: the line is only taken over after a fetch has returned
    a_r5_oe_after_fetch: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_q) |-> $past(req_q.rd, 2));

    // R7: driving stops once select is seen high
    a_r7_oe_release: assert property (@(posedge clk) disable iff (rst)
        sel_s_i |=> !oe_q);

    // R7: driving holds while select stays low
    a_r7_oe_hold: assert property (@(posedge clk) disable iff (rst)
        (oe_q && !sel_s_i) |=> oe_q);

    // R9: no strobe follows an idle cycle
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |=> !(req_q.wr || req_q.rd));

    // R10: never drive the line while writing
    a_r10_wr_not_driven: assert property (@(posedge clk) disable iff (rst)
        req_q.wr |-> !oe_q);

endmodule

// File: rtl/ser3_port.sv
module ser3_port
    import ser3_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n_i,
    input  logic              sck_i,
    input  logic              sda_i,
    output logic              sda_o,
    output logic              sda_oe_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_wr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    output logic              mem_rd_o,
    input  logic [BYTE_W-1:0] mem_rdata_i
);

    localparam int PIN_N = 3;

    logic [PIN_N-1:0] pins_s;
    logic             sel_s, sck_s, sda_s;
    logic             sel_fall, sck_rise, sck_fall;
    ser3_req_t        req;

    ser3_sync #(
        .WIDTH  (PIN_N),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b110)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d_i({sel_n_i, sck_i, sda_i}),
        .q_o(pins_s)
    );

    assign {sel_s, sck_s, sda_s} = pins_s;

    ser3_edge #(.RISING(1'b0), .IDLE_LV(1'b1)) u_sel_fall (
        .clk(clk), .rst(rst), .lvl_i(sel_s), .hit_o(sel_fall));

    ser3_edge #(.RISING(1'b1), .IDLE_LV(1'b1)) u_sck_rise (
        .clk(clk), .rst(rst), .lvl_i(sck_s), .hit_o(sck_rise));

    ser3_edge #(.RISING(1'b0), .IDLE_LV(1'b1)) u_sck_fall (
        .clk(clk), .rst(rst), .lvl_i(sck_s), .hit_o(sck_fall));

    ser3_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sel_s_i   (sel_s),
        .sel_fall_i(sel_fall),
        .sck_rise_i(sck_rise),
        .sck_fall_i(sck_fall),
        .sda_s_i   (sda_s),
        .rdata_i   (mem_rdata_i),
        .req_o     (req),
        .sda_o     (sda_o),
        .sda_oe_o  (sda_oe_o)
    );

    assign mem_addr_o  = req.addr;
    assign mem_wr_o    = req.wr;
    assign mem_rd_o    = req.rd;
    assign mem_wdata_o = req.data;

endmodule

// File: tb/ser3_port_tb.sv
module ser3_port_tb;

    localparam int HALF = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1;
    logic        sck = 1'b1;
    logic        sda = 1'b0;
    logic        sda_o, sda_oe;
    logic [13:0] mem_addr;
    logic        mem_wr, mem_rd;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;

    logic [7:0]  model [256];
    logic [13:0] wlog_a [32];
    logic [7:0]  wlog_d [32];
    int          wn = 0;
    int          rn = 0;
    int          nchk = 0;
    int          nfail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    ser3_port u_dut (
        .clk(clk), .rst(rst), .sel_n_i(sel_n), .sck_i(sck), .sda_i(sda),
        .sda_o(sda_o), .sda_oe_o(sda_oe), .mem_addr_o(mem_addr),
        .mem_wr_o(mem_wr), .mem_wdata_o(mem_wdata), .mem_rd_o(mem_rd),
        .mem_rdata_i(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_wr) begin
            model[mem_addr[7:0]] <= mem_wdata;
            wlog_a[wn[4:0]] <= mem_addr;
            wlog_d[wn[4:0]] <= mem_wdata;
            wn <= wn + 1;
        end
        if (mem_rd) begin
            mem_rdata <= model[mem_addr[7:0]];
            rn <= rn + 1;
        end
    end

    // {ignored bit, address, data}
    localparam logic [22:0] VEC [6] = '{
        {1'b0, 14'h0000, 8'hA5},
        {1'b0, 14'h2FFF, 8'h3C},
        {1'b1, 14'h1555, 8'h01},
        {1'b0, 14'h2AAA, 8'h80},
        {1'b1, 14'h0123, 8'hFF},
        {1'b0, 14'h3F80, 8'h7E}
    };

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        @(negedge clk); sck = 1'b0; sda = b;
        idle(HALF);
        sck = 1'b1;
        idle(HALF);
    endtask

    task automatic put_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) put_bit(v[i]);
    endtask

    task automatic get_byte(output logic [7:0] v, output logic oe_seen);
        oe_seen = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); sck = 1'b0;
            idle(HALF);
            v[i] = sda_o;
            oe_seen = oe_seen & sda_oe;
            sck = 1'b1;
            idle(HALF);
        end
    endtask

    task automatic open_xfer(input logic rw, input logic ign, input logic [13:0] a);
        @(negedge clk); sck = 1'b1; sel_n = 1'b0;
        idle(HALF);
        put_byte({rw, ign, a[13:8]});
        put_byte(a[7:0]);
        if (rw) idle(8);
    endtask

    task automatic close_xfer;
        @(negedge clk); sck = 1'b1; sel_n = 1'b1;
        idle(6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rb;
        logic       oe_ok;
        int         w0, r0;

        idle(4);
        // R1: reset state
        chk("R1 oe", int'(sda_oe), 0);
        chk("R1 wr", int'(mem_wr), 0);
        chk("R1 rd", int'(mem_rd), 0);
        @(negedge clk); rst = 1'b0;
        idle(4);

        for (int k = 0; k < 6; k++) begin
            w0 = wn; r0 = rn;
            open_xfer(1'b0, VEC[k][22], VEC[k][21:8]);
            put_byte(VEC[k][7:0]);
            idle(4);
            close_xfer();
            chk("R4 one write", wn - w0, 1);
            chk("R2 address", int'(wlog_a[w0[4:0]]), int'(VEC[k][21:8]));
            chk("R3 data", int'(wlog_d[w0[4:0]]), int'(VEC[k][7:0]));
            chk("R10 no read in write", rn - r0, 0);
            open_xfer(1'b1, VEC[k][22], VEC[k][21:8]);
            get_byte(rb, oe_ok);
            chk("R5 read data", int'(rb), int'(VEC[k][7:0]));
            chk("R7 oe held", int'(oe_ok), 1);
            close_xfer();
            chk("R7 oe released", int'(sda_oe), 0);
        end

        // R4 burst write across the top of the space
        w0 = wn; r0 = rn;
        open_xfer(1'b0, 1'b0, 14'h3FFE);
        put_byte(8'h11); put_byte(8'h22); put_byte(8'h33);
        idle(4);
        close_xfer();
        chk("R4 burst count", wn - w0, 3);
        chk("R4 addr 0", int'(wlog_a[w0[4:0]]), 'h3FFE);
        chk("R4 addr 1", int'(wlog_a[5'(w0 + 1)]), 'h3FFF);
        chk("R4 addr wrap", int'(wlog_a[5'(w0 + 2)]), 'h0000);
        chk("R4 data wrap", int'(wlog_d[5'(w0 + 2)]), 'h33);
        chk("R10 burst no read", rn - r0, 0);

        // R6 burst read
        open_xfer(1'b1, 1'b0, 14'h3FFE);
        get_byte(rb, oe_ok); chk("R6 byte 0", int'(rb), 'h11);
        get_byte(rb, oe_ok); chk("R6 byte 1", int'(rb), 'h22);
        get_byte(rb, oe_ok); chk("R6 byte 2", int'(rb), 'h33);
        chk("R7 oe through burst", int'(oe_ok), 1);
        close_xfer();
        chk("R7 oe after burst", int'(sda_oe), 0);

        // R8 abort inside a data byte, then a fresh transfer
        w0 = wn;
        open_xfer(1'b0, 1'b0, 14'h0010);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        close_xfer();
        chk("R8 no partial write", wn - w0, 0);
        open_xfer(1'b0, 1'b0, 14'h0011);
        put_byte(8'h5A);
        idle(4);
        close_xfer();
        chk("R8 restart count", wn - w0, 1);
        chk("R8 restart addr", int'(wlog_a[w0[4:0]]), 'h0011);
        chk("R8 restart data", int'(wlog_d[w0[4:0]]), 'h5A);

        // R9 activity while deselected
        w0 = wn; r0 = rn;
        oe_ok = 1'b0;
        for (int i = 0; i < 24; i++) begin
            put_bit(i[0]);
            oe_ok = oe_ok | sda_oe;
        end
        chk("R9 no write", wn - w0, 0);
        chk("R9 no read", rn - r0, 0);
        chk("R9 not driven", int'(oe_ok), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule